// File: doc/BRIEF.md
# Split-Register Serial Port Front End

This block is the register front end of a serial port that sits on a simple memory-mapped bus. Software sees three word-aligned registers inside a 4 KB window starting at 0x1000_0000: a write-only transmit register, a receive register that hands back one byte per read, and a read-only status word. The serial bit timing itself lives elsewhere. The block passes one byte at a time to a transmit serializer through a valid/ready pair, and it accepts one byte at a time from a receive deserializer through a strobe.

The bus side accepts a request in every cycle. A read returns its data exactly one cycle after it is accepted. Received bytes wait in a 16-entry FIFO until software reads them. Reading the receive register removes the byte it returns. Firmware polls the status word before each transmit write, because a write that arrives while the transmitter is busy is thrown away.

Top module: `mmio_serial_port`

## Requirements
- R1: After reset, tx_valid and bus_rsp_valid are low and the status word reads as zero.
- R2: A write to offset 0x0 while the transmitter is idle drives tx_valid high from the next cycle, with tx_data equal to bits 7:0 of the write data. Both hold steady until tx_ready is seen high.
- R3: A write to offset 0x0 while the transmitter is busy (a byte is pending, or tx_line_busy is high) is ignored. tx_valid and tx_data stay as they were.
- R4: The status word at offset 0x8 has bit 0 = transmitter busy (byte pending or tx_line_busy high) and bit 1 = receive FIFO not empty. Bits 31:2 read as zero.
- R5: A read of offset 0x4 returns the oldest queued byte in bits 7:0, with bits 31:8 zero, and removes that byte. Bytes come out in arrival order.
- R6: A read of offset 0x4 while the FIFO is empty returns zero and leaves the FIFO unchanged.
- R7: The FIFO holds 16 bytes. A byte strobed in while it is full is dropped, and the 16 queued bytes are kept.
- R8: bus_req_ready is always high. An accepted read raises bus_rsp_valid for exactly the next cycle. A write produces no response.
- R9: Writes to offsets 0x4 and 0x8 and writes outside the window have no effect. Reads of unmapped offsets or of addresses outside the window return zero and remove nothing.
- R10: tx_valid falls in the cycle after a cycle in which tx_valid and tx_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_valid | input | 1 | Bus request present |
| bus_req_ready | output | 1 | Request accepted (always high) |
| bus_req_write | input | 1 | 1 = write, 0 = read |
| bus_req_addr | input | 32 | Byte address |
| bus_req_wdata | input | 32 | Write data |
| bus_rsp_valid | output | 1 | Read data valid, one cycle after the read |
| bus_rsp_rdata | output | 32 | Read data |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_line_busy | input | 1 | Serializer is still shifting out a byte |
| rx_strobe | input | 1 | Deserializer delivers a byte this cycle |
| rx_byte | input | 8 | Received byte |

## Verification
The assertions assume that the serializer raises tx_ready only as a one-cycle acceptance, that rx_strobe is a single-cycle pulse, and that bus requests follow the bus rules: one request per cycle, with the address stable while valid is high. The bench drives every input on the falling edge. It presents each bus request for exactly one cycle and pulses rx_strobe for one cycle per byte. It never strobes a received byte in the same cycle as a receive-register read, so the overflow boundary is tested on a FIFO that is plainly full.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WIN_W   = 12;
    localparam logic [BUS_W-1:0] PORT_BASE = 32'h1000_0000;

    localparam logic [WIN_W-1:0] OFS_TXD  = 12'h000;
    localparam logic [WIN_W-1:0] OFS_RXD  = 12'h004;
    localparam logic [WIN_W-1:0] OFS_STAT = 12'h008;

    localparam int unsigned STAT_TXBUSY = 0;
    localparam int unsigned STAT_RXAVL  = 1;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_TXD,
        SEL_RXD,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     rd;
        logic     wr;
    } req_dec_t;

    function automatic logic [BUS_W-1:0] pack_status(input logic tx_busy, input logic rx_avail);
        logic [BUS_W-1:0] w;
        w = '0;
        w[STAT_TXBUSY] = tx_busy;
        w[STAT_RXAVL]  = rx_avail;
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
        return {{(BUS_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/sport_decode.sv
module sport_decode
    import sport_pkg::*;
(
    input  logic             valid,
    input  logic             write,
    input  logic [BUS_W-1:0] addr,
    output req_dec_t         dec
);
    logic             in_window;
    logic [WIN_W-1:0] offset;

    assign in_window = (addr[BUS_W-1:WIN_W] == PORT_BASE[BUS_W-1:WIN_W]);
    assign offset    = addr[WIN_W-1:0];

    always_comb begin
        dec.rd  = valid && !write;
        dec.wr  = valid && write;
        dec.sel = SEL_NONE;
        if (valid && in_window) begin
            unique case (offset)
                OFS_TXD:  dec.sel = SEL_TXD;
                OFS_RXD:  dec.sel = SEL_RXD;
                OFS_STAT: dec.sel = SEL_STAT;
                default:  dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sport_rx_fifo.sv
module sport_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW:0]      wptr;
    logic [AW:0]      rptr;
    logic             do_push;
    logic             do_pop;

    assign empty   = (wptr == rptr);
    assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr[AW-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> $stable(wptr));

    a_r6_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> $stable(rptr));

    a_r7_fill_limit: assert property (@(posedge clk) disable iff (rst)
        (wptr - rptr) <= (AW+1)'(DEPTH));
endmodule

// File: rtl/sport_tx_hold.sv
module sport_tx_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             line_busy,
    input  logic             ready,
    output logic             valid,
    output logic [WIDTH-1:0] data,
    output logic             busy
);
    logic             pend_q;
    logic [WIDTH-1:0] byte_q;

    assign busy  = pend_q || line_busy;
    assign valid = pend_q;
    assign data  = byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            byte_q <= '0;
        end else if (pend_q) begin
            if (ready) pend_q <= 1'b0;
        end else if (load && !line_busy) begin
            pend_q <= 1'b1;
            byte_q <= load_data;
        end
    end

    a_r2_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(data)));

    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !valid);

    a_r3_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (load && line_busy && !valid) |=> !valid);
endmodule

// File: rtl/mmio_serial_port.sv
module mmio_serial_port
    import sport_pkg::*;
#(
    parameter int unsigned RX_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req_valid,
    output logic              bus_req_ready,
    input  logic              bus_req_write,
    input  logic [BUS_W-1:0]  bus_req_addr,
    input  logic [BUS_W-1:0]  bus_req_wdata,
    output logic              bus_rsp_valid,
    output logic [BUS_W-1:0]  bus_rsp_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              tx_line_busy,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_byte
);
    req_dec_t          dec;
    logic              tx_busy;
    logic              rx_pop;
    logic [BYTE_W-1:0] rx_head;
    logic              rx_empty;
    logic              rx_full;
    logic [BUS_W-1:0]  rd_word;
    logic              stat_rd_q;

    assign bus_req_ready = 1'b1;

    sport_decode u_dec (
        .valid (bus_req_valid),
        .write (bus_req_write),
        .addr  (bus_req_addr),
        .dec   (dec)
    );

    sport_tx_hold #(.WIDTH(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (dec.wr && dec.sel == SEL_TXD),
        .load_data (bus_req_wdata[BYTE_W-1:0]),
        .line_busy (tx_line_busy),
        .ready     (tx_ready),
        .valid     (tx_valid),
        .data      (tx_data),
        .busy      (tx_busy)
    );

    assign rx_pop = dec.rd && dec.sel == SEL_RXD;

    sport_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_strobe),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_RXD:  rd_word = rx_empty ? '0 : zext_byte(rx_head);
            SEL_STAT: rd_word = pack_status(tx_busy, !rx_empty);
            default:  rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rsp_valid <= 1'b0;
            bus_rsp_rdata <= '0;
            stat_rd_q     <= 1'b0;
        end else begin
            bus_rsp_valid <= dec.rd;
            stat_rd_q     <= dec.rd && dec.sel == SEL_STAT;
            if (dec.rd) bus_rsp_rdata <= rd_word;
        end
    end

    a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_rsp_valid |-> $past(bus_req_valid && !bus_req_write));

    a_r8_single_rsp: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && !bus_req_write) |=> bus_rsp_valid);

    a_r4_status_clean: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && stat_rd_q) |-> (bus_rsp_rdata[BUS_W-1:2] == '0));

    a_r5_rx_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && !stat_rd_q) |-> (bus_rsp_rdata[BUS_W-1:BYTE_W] == '0));

    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rx_strobe && !rx_pop) |=> rx_full);
endmodule

// File: tb/mmio_serial_port_test.sv
`timescale 1ns/1ps
module mmio_serial_port_test;
    localparam logic [31:0] A_TXD  = 32'h1000_0000;
    localparam logic [31:0] A_RXD  = 32'h1000_0004;
    localparam logic [31:0] A_STAT = 32'h1000_0008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req_valid = 1'b0;
    logic        bus_req_ready;
    logic        bus_req_write = 1'b0;
    logic [31:0] bus_req_addr  = '0;
    logic [31:0] bus_req_wdata = '0;
    logic        bus_rsp_valid;
    logic [31:0] bus_rsp_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        tx_line_busy = 1'b0;
    logic        rx_strobe = 1'b0;
    logic [7:0]  rx_byte = '0;

    int n_checks = 0;
    int n_bad    = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mmio_serial_port uut (
        .clk, .rst, .bus_req_valid, .bus_req_ready, .bus_req_write,
        .bus_req_addr, .bus_req_wdata, .bus_rsp_valid, .bus_rsp_rdata,
        .tx_valid, .tx_data, .tx_ready, .tx_line_busy, .rx_strobe, .rx_byte
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req_valid = 1'b1; bus_req_write = 1'b1;
        bus_req_addr = a; bus_req_wdata = d;
        @(negedge clk);
        bus_req_valid = 1'b0; bus_req_write = 1'b0;
        chk("R8 no response to write", {31'd0, bus_rsp_valid}, 32'd0);
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req_valid = 1'b1; bus_req_write = 1'b0; bus_req_addr = a;
        @(negedge clk);
        bus_req_valid = 1'b0;
        chk("R8 response one cycle after read", {31'd0, bus_rsp_valid}, 32'd1);
        d = bus_rsp_rdata;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_strobe = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        chk("R1 rsp_valid after reset", {31'd0, bus_rsp_valid}, 32'd0);
        chk("R8 ready high", {31'd0, bus_req_ready}, 32'd1);
        bus_read(A_STAT, d);
        chk("R1 status after reset", d, 32'd0);
    endtask

    task automatic t_rsp_timing();
        logic [31:0] d;
        bus_read(A_STAT, d);
        @(negedge clk);
        chk("R8 response lasts one cycle", {31'd0, bus_rsp_valid}, 32'd0);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        bus_write(A_TXD, 32'hFFFF_FFA5);
        chk("R2 tx_valid raised", {31'd0, tx_valid}, 32'd1);
        chk("R2 tx_data low byte", {24'd0, tx_data}, 32'h0000_00A5);
        bus_read(A_STAT, d);
        chk("R4 status busy while pending", d, 32'd1);
        bus_write(A_TXD, 32'h0000_0033);
        chk("R3 pending byte kept", {24'd0, tx_data}, 32'h0000_00A5);
        chk("R2 still offered", {31'd0, tx_valid}, 32'd1);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R10 tx_valid drops after handshake", {31'd0, tx_valid}, 32'd0);
        bus_read(A_STAT, d);
        chk("R4 status idle", d, 32'd0);
        tx_line_busy = 1'b1;
        bus_read(A_STAT, d);
        chk("R4 status busy from line", d, 32'd1);
        bus_write(A_TXD, 32'h0000_0044);
        chk("R3 write while line busy ignored", {31'd0, tx_valid}, 32'd0);
        tx_line_busy = 1'b0;
        bus_write(A_TXD, 32'h0000_0044);
        chk("R2 second byte", {23'd0, tx_valid, tx_data}, 32'h0000_0144);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R10 second release", {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_rx_order();
        logic [31:0] d;
        rx_push(8'h11); rx_push(8'hC2); rx_push(8'h03);
        bus_read(A_STAT, d);
        chk("R4 status rx available", d, 32'd2);
        bus_read(A_RXD, d); chk("R5 first byte", d, 32'h11);
        bus_read(A_RXD, d); chk("R5 second byte", d, 32'hC2);
        bus_read(A_RXD, d); chk("R5 third byte", d, 32'h03);
        bus_read(A_STAT, d);
        chk("R4 status drained", d, 32'd0);
    endtask

    task automatic t_rx_empty();
        logic [31:0] d;
        bus_read(A_RXD, d);
        chk("R6 empty read zero", d, 32'd0);
        rx_push(8'h77);
        bus_read(A_RXD, d);
        chk("R6 pointers unchanged by empty read", d, 32'h77);
        bus_read(A_STAT, d);
        chk("R6 empty again", d, 32'd0);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < 17; i++) rx_push(8'(8'h20 + i));
        for (int i = 0; i < 16; i++) begin
            bus_read(A_RXD, d);
            chk("R7 queued byte kept", d, 32'(8'h20 + i));
        end
        bus_read(A_RXD, d);
        chk("R7 overflow byte dropped", d, 32'd0);
    endtask

    task automatic t_no_effect();
        logic [31:0] d;
        rx_push(8'h5C);
        bus_write(A_RXD, 32'h0000_00EE);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_write(32'h2000_0000, 32'h0000_0099);
        chk("R9 stray writes leave tx idle", {31'd0, tx_valid}, 32'd0);
        bus_read(32'h2000_0008, d);
        chk("R9 outside window reads zero", d, 32'd0);
        bus_read(32'h2000_0004, d);
        chk("R9 outside window pops nothing", d, 32'd0);
        bus_read(32'h1000_000C, d);
        chk("R9 unmapped offset zero", d, 32'd0);
        bus_read(A_TXD, d);
        chk("R9 tx register reads zero", d, 32'd0);
        bus_read(A_STAT, d);
        chk("R9 status unaffected", d, 32'd2);
        bus_read(A_RXD, d);
        chk("R9 rx byte survived", d, 32'h5C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rsp_timing();
        t_tx();
        t_rx_order();
        t_rx_empty();
        t_full();
        t_no_effect();
        finished = 1;
        summary();
    end
endmodule